// File: doc/BRIEF.md
# Instruction Cache Control and Invalidation Sequencer

This block is the control plane of a small instruction cache. Software reaches it through a word-addressed register port that holds a control register, a sticky status register, an interrupt enable register, an interrupt clear register and a fixed identification window. The block does not hold tags or data. It drives a valid-bit clear port that a line-by-line walker steps through, and for every fetch it gives a decision: use the cache, or pass the fetch through uncached.

Straight out of reset the walker clears every line. Fetches bypass the cache until the walk is over and the enable bit is set. When software turns caching off, the block waits for all outstanding fetches to return before it reports the disable as complete. The end of a walk and the end of a disable each set their own sticky status bit. A level interrupt is raised while any status bit is set and that bit's enable is also set. A register access is honoured only when the requester is both secure and privileged.

Top module: `icache_ctl_seq`

## Requirements
- R1: After reset, a walk is active with `vclr_en`=1 and `vclr_idx`=0. `fetch_cacheable`, `irq`, the control readback (offset 0x000) and the status readback (offset 0x004) are all 0.
- R2: While the enable bit (control bit 0) is 0, `fetch_cacheable` is 0.
- R3: Writing enable=1 during a walk has no effect while the walk runs. Once the walk ends, `fetch_cacheable` becomes 1 with no further write.
- R4: On the clock edge that retires the last line, status bit 0 (walk done) becomes 1. The bit stays set until it is cleared.
- R5: `irq` is 1 exactly when some status bit and the matching bit of the enable register (offset 0x008) are both 1. The order in which the two were set does not matter.
- R6: When the enable bit is cleared, fetches bypass from the next cycle. Status bit 1 (disable done) becomes 1 only on the edge after the outstanding-fetch count, which goes up on `fetch_req` and down on `fetch_rsp`, has reached zero.
- R7: A permitted write to the control register with bit 1 (partial) or bit 2 (full) set starts a full walk. On the next edge `vclr_idx` is 0. This also restarts a walk that is already running.
- R8: While `vclr_en` is 1, `fetch_cacheable` is 0.
- R9: Reads at 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8 and 0xFFC return 0x0B, 0x00, 0x0D, 0xF0, 0x05 and 0xB1. Writes to these addresses are ignored. Unmapped addresses read 0 with no error.
- R10: An access without both `reg_secure` and `reg_priv` set raises `reg_err`, reads 0 and changes no state.
- R11: The walker clears one line per clock in ascending order and covers LINES lines.
- R12: Writing 1s to the clear register (offset 0x00C) clears those status bits. If a status bit is set in the same cycle it is cleared, the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address in the register window |
| reg_wdata | input | 32 | Write data |
| reg_secure | input | 1 | Requester is secure |
| reg_priv | input | 1 | Requester is privileged |
| reg_rdata | output | 32 | Read data, valid in the same cycle |
| reg_err | output | 1 | Access refused |
| fetch_req | input | 1 | A fetch is issued this cycle |
| fetch_rsp | input | 1 | A fetch completes this cycle |
| fetch_cacheable | output | 1 | 1 = cache the fetch, 0 = bypass |
| vclr_en | output | 1 | Clear the valid bit of line `vclr_idx` |
| vclr_idx | output | $clog2(LINES) | Line being cleared |
| irq | output | 1 | Level interrupt |

## Verification
Reads and `reg_err` are combinational, so the bench samples them one time unit after it drives the request, before any clock edge. A register write takes effect on the single edge inside the write task, so the enable bit, the interrupt enables and the walk restart are all visible at the next falling edge. The last-line edge and the edge after the outstanding count reaches zero are the two status-setting edges. The bench counts edges explicitly to each of them and checks the status bit one edge before, where it must still be 0, and at that edge, where it must be 1.

// File: rtl/icc_pkg.sv
package icc_pkg;
   localparam int OFS_CTRL  = 'h000;
   localparam int OFS_STAT  = 'h004;
   localparam int OFS_IEN   = 'h008;
   localparam int OFS_ICLR  = 'h00C;
   localparam int ID_FIRST  = 'hFE8;
   localparam int ID_LAST   = 'hFFC;
   localparam int CTRL_EN   = 0;
   localparam int CTRL_PINV = 1;
   localparam int CTRL_FINV = 2;
   localparam int NUM_ST    = 2;   // bit0 walk done, bit1 disable done

   function automatic logic [7:0] id_byte(input logic [2:0] slot);
      case (slot)
         3'd0:    id_byte = 8'h0B;
         3'd1:    id_byte = 8'h00;
         3'd2:    id_byte = 8'h0D;
         3'd3:    id_byte = 8'hF0;
         3'd4:    id_byte = 8'h05;
         3'd5:    id_byte = 8'hB1;
         default: id_byte = 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/icc_inv_walker.sv
module icc_inv_walker #(
   parameter int LINES  = 64,
   parameter int LIDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   output logic              active,
   output logic [LIDX_W-1:0] idx,
   output logic              done
);
   localparam logic [LIDX_W-1:0] LAST = LIDX_W'(LINES - 1);
   logic at_last;

   assign at_last = (idx == LAST);
   assign done    = active & at_last & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (restart) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (active) begin
         if (at_last) active <= 1'b0;
         else         idx    <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/icc_fetch_track.sv
module icc_fetch_track #(
   parameter int OUTST_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_bit,
   input  logic               walking,
   input  logic               fetch_req,
   input  logic               fetch_rsp,
   output logic               cacheable,
   output logic               dis_done,
   output logic [OUTST_W-1:0] outst
);
   localparam logic [OUTST_W-1:0] CNT_MAX = '1;
   logic cache_on;

   assign cacheable = en_bit & ~walking;
   assign dis_done  = ~en_bit & cache_on & (outst == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cache_on <= 1'b0;
      end else if (en_bit & ~walking) begin
         cache_on <= 1'b1;
      end else if (dis_done) begin
         cache_on <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst <= '0;
      end else begin
         case ({fetch_req, fetch_rsp})
            2'b10:   if (outst != CNT_MAX) outst <= outst + 1'b1;
            2'b01:   if (outst != '0)      outst <= outst - 1'b1;
            default: outst <= outst;
         endcase
      end
   end
endmodule

// File: rtl/icc_regs.sv
module icc_regs
   import icc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter bit ID_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_secure,
   input  logic              reg_priv,
   output logic [31:0]       reg_rdata,
   output logic              reg_err,
   input  logic              inv_done,
   input  logic              dis_done,
   output logic              en_bit,
   output logic              inv_start,
   output logic              irq,
   output logic [NUM_ST-1:0] stat_q
);
   localparam int WORD_W = ADDR_W - 2;

   logic              acc_ok, wr_ok, rd_ok;
   logic [WORD_W-1:0] word;
   logic              hit_ctrl, hit_stat, hit_ien, hit_iclr;
   logic              id_hit;
   logic [7:0]        id_val;
   logic [NUM_ST-1:0] ien_q, st_set, st_clr;
   logic              unused_bits;

   assign acc_ok   = reg_sel & reg_secure & reg_priv;
   assign wr_ok    = acc_ok & reg_wr;
   assign rd_ok    = acc_ok & ~reg_wr;
   assign word     = reg_addr[ADDR_W-1:2];
   assign hit_ctrl = (word == WORD_W'(OFS_CTRL >> 2));
   assign hit_stat = (word == WORD_W'(OFS_STAT >> 2));
   assign hit_ien  = (word == WORD_W'(OFS_IEN  >> 2));
   assign hit_iclr = (word == WORD_W'(OFS_ICLR >> 2));
   assign reg_err  = reg_sel & ~(reg_secure & reg_priv);
   assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:NUM_ST+1]};

   generate
      if (ID_EN) begin : g_id
         logic [WORD_W-1:0] slot;
         assign slot   = word - WORD_W'(ID_FIRST >> 2);
         assign id_hit = (word >= WORD_W'(ID_FIRST >> 2)) && (word <= WORD_W'(ID_LAST >> 2));
         assign id_val = id_byte(slot[2:0]);
      end else begin : g_no_id
         assign id_hit = 1'b0;
         assign id_val = 8'h00;
      end
   endgenerate

   assign inv_start = wr_ok & hit_ctrl & (reg_wdata[CTRL_PINV] | reg_wdata[CTRL_FINV]);
   assign st_set    = {dis_done, inv_done};
   assign st_clr    = (wr_ok & hit_iclr) ? reg_wdata[NUM_ST-1:0] : '0;
   assign irq       = |(stat_q & ien_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_bit <= 1'b0;
         ien_q  <= '0;
         stat_q <= '0;
      end else begin
         if (wr_ok & hit_ctrl) en_bit <= reg_wdata[CTRL_EN];
         if (wr_ok & hit_ien)  ien_q  <= reg_wdata[NUM_ST-1:0];
         stat_q <= (stat_q & ~st_clr) | st_set;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (rd_ok) begin
         if (hit_ctrl)     reg_rdata[CTRL_EN]  = en_bit;
         else if (hit_stat) reg_rdata[NUM_ST-1:0] = stat_q;
         else if (hit_ien)  reg_rdata[NUM_ST-1:0] = ien_q;
         else if (id_hit)   reg_rdata[7:0] = id_val;
      end
   end
endmodule

// File: rtl/icache_ctl_seq.sv
module icache_ctl_seq
   import icc_pkg::*;
#(
   parameter int LINES   = 64,
   parameter int ADDR_W  = 12,
   parameter int OUTST_W = 4,
   parameter bit ID_EN   = 1'b1,
   localparam int LIDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_secure,
   input  logic              reg_priv,
   output logic [31:0]       reg_rdata,
   output logic              reg_err,
   input  logic              fetch_req,
   input  logic              fetch_rsp,
   output logic              fetch_cacheable,
   output logic              vclr_en,
   output logic [LIDX_W-1:0] vclr_idx,
   output logic              irq
);
   generate
      if (LINES < 2)   begin : g_bad_lines $error("LINES must be at least 2"); end
      if (ADDR_W < 12) begin : g_bad_addr  $error("ADDR_W must cover the 4 KiB window"); end
      if (OUTST_W < 1) begin : g_bad_cnt   $error("OUTST_W must be at least 1"); end
   endgenerate

   logic              en_bit, inv_start, inv_done, dis_done;
   logic [NUM_ST-1:0] stat_q;
   logic [OUTST_W-1:0] outst_q;

   icc_regs #(.ADDR_W(ADDR_W), .ID_EN(ID_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_secure(reg_secure),
      .reg_priv(reg_priv), .reg_rdata(reg_rdata), .reg_err(reg_err),
      .inv_done(inv_done), .dis_done(dis_done), .en_bit(en_bit),
      .inv_start(inv_start), .irq(irq), .stat_q(stat_q)
   );

   icc_inv_walker #(.LINES(LINES), .LIDX_W(LIDX_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .restart(inv_start),
      .active(vclr_en), .idx(vclr_idx), .done(inv_done)
   );

   icc_fetch_track #(.OUTST_W(OUTST_W)) u_track (
      .clk(clk), .rst_n(rst_n), .en_bit(en_bit), .walking(vclr_en),
      .fetch_req(fetch_req), .fetch_rsp(fetch_rsp),
      .cacheable(fetch_cacheable), .dis_done(dis_done), .outst(outst_q)
   );
endmodule

// File: rtl/icc_ctl_checker.sv
module icc_ctl_checker #(
   parameter int LINES   = 64,
   parameter int LIDX_W  = $clog2(LINES),
   parameter int OUTST_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               vclr_en,
   input logic [LIDX_W-1:0]  vclr_idx,
   input logic               fetch_cacheable,
   input logic               reg_sel,
   input logic               reg_secure,
   input logic               reg_priv,
   input logic               reg_err,
   input logic [31:0]        reg_rdata,
   input logic [1:0]         stat_q,
   input logic [OUTST_W-1:0] outst_q,
   input logic               inv_start
);
   localparam logic [LIDX_W-1:0] LAST = LIDX_W'(LINES - 1);

   a_r8_walk_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      vclr_en |-> !fetch_cacheable);

   a_r10_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && !(reg_secure && reg_priv)) |-> (reg_err && reg_rdata == 32'd0));

   a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
      (vclr_en && vclr_idx != LAST && !inv_start) |=>
         (vclr_en && vclr_idx == LIDX_W'($past(vclr_idx) + 1'b1)));

   a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (vclr_en && vclr_idx == LAST && !inv_start) |=> (stat_q[0] && !vclr_en));

   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      inv_start |=> (vclr_en && vclr_idx == '0));

   a_r6_drained: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[1]) |-> ($past(outst_q) == '0));
endmodule

bind icache_ctl_seq icc_ctl_checker #(.LINES(LINES), .LIDX_W(LIDX_W), .OUTST_W(OUTST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vclr_en(vclr_en), .vclr_idx(vclr_idx),
   .fetch_cacheable(fetch_cacheable), .reg_sel(reg_sel), .reg_secure(reg_secure),
   .reg_priv(reg_priv), .reg_err(reg_err), .reg_rdata(reg_rdata),
   .stat_q(stat_q), .outst_q(outst_q), .inv_start(inv_start)
);

// File: tb/icache_ctl_seq_test.sv
module icache_ctl_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int LINES  = 16;
   localparam int LIDX_W = $clog2(LINES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_sel = 0, reg_wr = 0, reg_secure = 0, reg_priv = 0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic reg_err;
   logic fetch_req = 0, fetch_rsp = 0;
   logic fetch_cacheable, vclr_en, irq;
   logic [LIDX_W-1:0] vclr_idx;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   icache_ctl_seq #(.LINES(LINES)) uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_secure(reg_secure),
      .reg_priv(reg_priv), .reg_rdata(reg_rdata), .reg_err(reg_err),
      .fetch_req(fetch_req), .fetch_rsp(fetch_rsp), .fetch_cacheable(fetch_cacheable),
      .vclr_en(vclr_en), .vclr_idx(vclr_idx), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one clock edge per write
   task automatic wr(input logic [11:0] a, input logic [31:0] d,
                     input logic sec = 1'b1, input logic prv = 1'b1);
      reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
      reg_secure = sec; reg_priv = prv;
      @(negedge clk);
      reg_sel = 0; reg_wr = 0; reg_secure = 0; reg_priv = 0;
   endtask

   // no clock edge: combinational read
   task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e,
                     input logic sec = 1'b1, input logic prv = 1'b1);
      reg_sel = 1; reg_wr = 0; reg_addr = a; reg_secure = sec; reg_priv = prv;
      #1;
      d = reg_rdata; e = reg_err;
      reg_sel = 0; reg_secure = 0; reg_priv = 0;
   endtask

   task automatic pulse_fetch(input bit is_req);
      if (is_req) fetch_req = 1; else fetch_rsp = 1;
      @(negedge clk);
      fetch_req = 0; fetch_rsp = 0;
   endtask

   function automatic logic [31:0] exp_fixed(input logic [11:0] a);
      case (a & 12'hFFC)
         12'hFE8: exp_fixed = 32'h0B;
         12'hFEC: exp_fixed = 32'h00;
         12'hFF0: exp_fixed = 32'h0D;
         12'hFF4: exp_fixed = 32'hF0;
         12'hFF8: exp_fixed = 32'h05;
         12'hFFC: exp_fixed = 32'hB1;
         default: exp_fixed = 32'h0;
      endcase
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic e;
      void'($urandom(32'd1234));
      step(3);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 vclr_en", {31'b0, vclr_en}, 1);
      check("R1 vclr_idx", 32'(vclr_idx), 0);
      check("R1 cacheable", {31'b0, fetch_cacheable}, 0);
      check("R1 irq", {31'b0, irq}, 0);
      rd(12'h000, d, e); check("R1 ctrl", d, 0);
      rd(12'h004, d, e); check("R1 stat", d, 0);
      // R11 one line per clock
      step(3);
      check("R11 idx after 3", 32'(vclr_idx), 3);
      // R3 enable mid-walk
      wr(12'h000, 32'h1);
      check("R3 still bypass", {31'b0, fetch_cacheable}, 0);
      check("R8 walk bypass", {31'b0, vclr_en}, 1);
      step(LINES - 5);
      check("R11 last line", 32'(vclr_idx), LINES - 1);
      rd(12'h004, d, e); check("R4 not yet", d, 0);
      step(1);
      check("R11 walk over", {31'b0, vclr_en}, 0);
      rd(12'h004, d, e); check("R4 walk done", d, 1);
      check("R3 cacheable after walk", {31'b0, fetch_cacheable}, 1);
      // R5 enable after status
      check("R5 no enable", {31'b0, irq}, 0);
      wr(12'h008, 32'h1);
      check("R5 late enable", {31'b0, irq}, 1);
      wr(12'h00C, 32'h1);
      rd(12'h004, d, e); check("R12 cleared", d, 0);
      check("R5 irq drops", {31'b0, irq}, 0);
      // R7 partial request, then full restart mid-walk
      wr(12'h000, 32'h3);
      check("R7 partial restarts", {31'b0, vclr_en, 31'(vclr_idx)} , {1'b1, 31'd0});
      check("R8 bypass during walk", {31'b0, fetch_cacheable}, 0);
      rd(12'h000, d, e); check("R7 request self-clears", d, 1);
      step(5);
      check("R11 idx 5", 32'(vclr_idx), 5);
      wr(12'h000, 32'h5);
      check("R7 full restarts", 32'(vclr_idx), 0);
      step(LINES - 1);
      check("R7 restarted walk length", 32'(vclr_idx), LINES - 1);
      check("R5 not pending", {31'b0, irq}, 0);
      // R12 set and clear in one cycle
      wr(12'h00C, 32'h1);
      rd(12'h004, d, e); check("R12 set wins", d, 1);
      check("R5 enabled first", {31'b0, irq}, 1);
      wr(12'h00C, 32'h1);
      rd(12'h004, d, e); check("R12 clear", d, 0);
      // R6 disable waits for drain
      check("R6 cacheable before", {31'b0, fetch_cacheable}, 1);
      pulse_fetch(1); pulse_fetch(1);
      wr(12'h000, 32'h0);
      check("R6 bypass on disable", {31'b0, fetch_cacheable}, 0);
      step(3);
      rd(12'h004, d, e); check("R6 pending two", d, 0);
      pulse_fetch(0);
      rd(12'h004, d, e); check("R6 pending one", d, 0);
      pulse_fetch(0);
      rd(12'h004, d, e); check("R6 count just zero", d, 0);
      step(1);
      rd(12'h004, d, e); check("R6 disable done", d, 2);
      check("R5 bit1 masked", {31'b0, irq}, 0);
      wr(12'h008, 32'h2);
      check("R5 bit1 enabled", {31'b0, irq}, 1);
      wr(12'h00C, 32'h2);
      // R2 disabled fetch bypass
      fetch_req = 1; #1;
      check("R2 disabled bypass", {31'b0, fetch_cacheable}, 0);
      @(negedge clk); fetch_req = 0;
      pulse_fetch(0);
      // disable with nothing outstanding
      wr(12'h000, 32'h1);
      step(1);
      wr(12'h000, 32'h0);
      rd(12'h004, d, e); check("R6 idle one edge", d, 0);
      step(1);
      rd(12'h004, d, e); check("R6 idle done", d, 2);
      wr(12'h00C, 32'h3);
      // R10 refused accesses
      rd(12'h000, d, e, 1'b1, 1'b0); check("R10 read data", d, 0); check("R10 err", {31'b0, e}, 1);
      rd(12'hFF0, d, e, 1'b0, 1'b1); check("R10 id refused", d, 0);
      reg_sel = 1; reg_wr = 1; reg_addr = 12'h008; reg_wdata = 32'h1; reg_secure = 0; reg_priv = 1;
      #1; check("R10 write err", {31'b0, reg_err}, 1);
      @(negedge clk); reg_sel = 0; reg_wr = 0;
      rd(12'h008, d, e); check("R10 write ignored", d, 2);
      wr(12'h000, 32'h4, 1'b1, 1'b0);
      check("R10 no walk", {31'b0, vclr_en}, 0);
      // R9 identification window
      for (int i = 0; i < 6; i++) begin
         rd(12'(12'hFE8 + 4*i), d, e);
         check("R9 id value", d, exp_fixed(12'(12'hFE8 + 4*i)));
         check("R9 id no err", {31'b0, e}, 0);
      end
      wr(12'hFF0, 32'hFF);
      rd(12'hFF0, d, e); check("R9 id write ignored", d, 32'h0D);
      rd(12'h200, d, e); check("R9 unmapped", d, 0); check("R9 unmapped no err", {31'b0, e}, 0);
      // random reads over fixed-value space with random permissions
      for (int n = 0; n < 60; n++) begin
         logic [11:0] a;
         logic s, p;
         a = 12'($urandom_range(12'h3FF, 12'h010)) << 2;
         if (n % 3 == 0) a = 12'hFE8 + 12'($urandom_range(5, 0) * 4);
         s = 1'($urandom); p = 1'($urandom);
         rd(a, d, e, s, p);
         check("R10 random err", {31'b0, e}, {31'b0, ~(s & p)});
         check("R9 random data", d, (s & p) ? exp_fixed(a) : 32'h0);
      end
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule